// File: doc/BRIEF.md
# Hashed MAC Address Lookup Table

This block maps a 48-bit destination MAC address to an output port number. A request folds the address into an 8-bit bucket index by XOR. The block then walks the eight slots of that bucket, one slot per clock, and stops at the first valid slot whose stored address equals the requested one. It reports the result with a single-cycle done strobe, carrying a hit flag, the stored port number and the stored static flag.

Entries are loaded through a separate write port that names a bucket, a slot, and the contents of that slot. The writer chooses the bucket and the slot; the block makes no placement decisions. While a search is running the block shows busy and ignores further requests.

Top module: `mac_hash_lookup`

## Requirements
- R1: After reset, lk_done, lk_busy, lk_hit, lk_port and lk_static are all 0, and every slot is invalid, so any lookup misses.
- R2: The bucket index is the XOR of the six bytes of the address (bits 7:0 ^ 15:8 ^ 23:16 ^ 31:24 ^ 39:32 ^ 47:40). Only the bucket with that index is searched, so an entry placed in any other bucket is never found.
- R3: A write with wr_en=1 at a clock edge replaces the slot wr_slot of bucket wr_bucket with wr_mac, wr_port, wr_static and wr_valid. Later lookups see the new contents.
- R4: On a hit, lk_hit=1 and lk_port and lk_static equal the values stored in the matching slot.
- R5: Slots are examined in order from 0 to 7, one per clock. If a request is accepted at rising edge t0, a hit in slot k raises lk_done after edge t0+k+1, and a miss raises it after edge t0+8.
- R6: When several valid slots of a bucket hold the same address, the one with the lowest slot number supplies the result.
- R7: A slot written with wr_valid=0 is skipped and never produces a hit, whatever address it holds.
- R8: A request is accepted only when lk_valid=1 and lk_busy=0. lk_busy is 1 from the cycle after acceptance until the result is given, and requests raised while busy are dropped with no later result.
- R9: lk_done is high for exactly one cycle per accepted request. lk_hit, lk_port and lk_static keep their values until the next lk_done.
- R10: On a miss, lk_hit, lk_port and lk_static are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Address to look up |
| lk_busy | output | 1 | Search in progress; requests are ignored |
| lk_done | output | 1 | One-cycle strobe: the result is valid |
| lk_hit | output | 1 | A matching valid slot was found |
| lk_port | output | 2 | Port number of the matching slot |
| lk_static | output | 1 | Static flag of the matching slot |
| wr_en | input | 1 | Slot write strobe |
| wr_bucket | input | 8 | Bucket to write |
| wr_slot | input | 3 | Slot within the bucket |
| wr_mac | input | 48 | Address to store |
| wr_port | input | 2 | Port number to store |
| wr_static | input | 1 | Static flag to store |
| wr_valid | input | 1 | Valid flag to store |

## Verification
A fault in the slot counter or the scan state shows first in the timing of lk_done. Done comes a wrong number of edges after acceptance, comes twice, or never comes. The bench measures that count for hits at slots 0, 3, 4, 7 and for misses. A wrong hash or a wrong slot address shows as a miss where a hit is expected, or as a hit in the wrong bucket, within eight cycles of the request. A broken priority or valid mask shows as a wrong lk_port on a bucket that holds duplicate or invalid slots.

// File: rtl/mhl_pkg.sv
package mhl_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scan_state_t;
endpackage

// File: rtl/mhl_hash.sv
module mhl_hash #(
   parameter int MAC_W = 48,
   parameter int IDX_W = 8
) (
   input  logic [MAC_W-1:0] mac_i,
   output logic [IDX_W-1:0] idx_o
);
   localparam int CHUNKS = MAC_W / IDX_W;

   if (MAC_W % IDX_W != 0) begin : g_bad_fold
      $error("mhl_hash: MAC_W must be a multiple of IDX_W");
   end

   logic [IDX_W-1:0] part [CHUNKS];

   for (genvar g = 0; g < CHUNKS; g++) begin : g_part
      assign part[g] = mac_i[g*IDX_W +: IDX_W];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < CHUNKS; i++) begin
         idx_o = idx_o ^ part[i];
      end
   end
endmodule

// File: rtl/mhl_table.sv
module mhl_table #(
   parameter int MAC_W      = 48,
   parameter int IDX_W      = 8,
   parameter int SLOT_W     = 3,
   parameter int PORT_W     = 2,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_bucket,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_valid,
   input  logic [MAC_W-1:0]  wr_mac,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              wr_static,
   input  logic [IDX_W-1:0]  rd_bucket,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_valid,
   output logic [MAC_W-1:0]  rd_mac,
   output logic [PORT_W-1:0] rd_port,
   output logic              rd_static
);
   localparam int ADDR_W = IDX_W + SLOT_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = MAC_W + PORT_W + 1;

   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [DEPTH-1:0]  vld_q;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_word;

   assign wr_addr = {wr_bucket, wr_slot};
   assign rd_addr = {rd_bucket, rd_slot};

   // valid flags always carry a reset so an empty table misses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_addr] <= wr_valid;
      end
   end

   if (RESET_DATA) begin : g_flop_data
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_en) begin
            mem[wr_addr] <= {wr_mac, wr_port, wr_static};
         end
      end
   end else begin : g_ram_data
      always_ff @(posedge clk) begin
         if (wr_en) begin
            mem[wr_addr] <= {wr_mac, wr_port, wr_static};
         end
      end
   end

   assign rd_word   = mem[rd_addr];
   assign rd_valid  = vld_q[rd_addr];
   assign rd_mac    = rd_word[DATA_W-1 -: MAC_W];
   assign rd_port   = rd_word[PORT_W:1];
   assign rd_static = rd_word[0];

   // R3: a slot that was just written reads back the written valid flag
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_addr)] == $past(wr_valid))); // R3
endmodule

// File: rtl/mhl_search.sv
module mhl_search
   import mhl_pkg::*;
#(
   parameter int MAC_W  = 48,
   parameter int IDX_W  = 8,
   parameter int WAYS   = 8,
   parameter int SLOT_W = 3,
   parameter int PORT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [MAC_W-1:0]  req_mac,
   input  logic [IDX_W-1:0]  req_bucket,
   output logic              busy_o,
   output logic [IDX_W-1:0]  rd_bucket,
   output logic [SLOT_W-1:0] rd_slot,
   input  logic              rd_valid,
   input  logic [MAC_W-1:0]  rd_mac,
   input  logic [PORT_W-1:0] rd_port,
   input  logic              rd_static,
   output logic              done_o,
   output logic              hit_o,
   output logic [PORT_W-1:0] port_o,
   output logic              static_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WAYS - 1);

   scan_state_t       state_q;
   logic [IDX_W-1:0]  bucket_q;
   logic [MAC_W-1:0]  mac_q;
   logic [SLOT_W-1:0] slot_q;
   logic              done_q;
   logic              hit_q;
   logic [PORT_W-1:0] port_q;
   logic              static_q;
   logic              match;
   logic              at_last;

   assign match   = (state_q == ST_SCAN) && rd_valid && (rd_mac == mac_q);
   assign at_last = (slot_q == LAST_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bucket_q <= '0;
         mac_q    <= '0;
         slot_q   <= '0;
         done_q   <= 1'b0;
         hit_q    <= 1'b0;
         port_q   <= '0;
         static_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  bucket_q <= req_bucket;
                  mac_q    <= req_mac;
                  slot_q   <= '0;
                  state_q  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (match) begin
                  done_q   <= 1'b1;
                  hit_q    <= 1'b1;
                  port_q   <= rd_port;
                  static_q <= rd_static;
                  state_q  <= ST_IDLE;
               end else if (at_last) begin
                  done_q   <= 1'b1;
                  hit_q    <= 1'b0;
                  port_q   <= '0;
                  static_q <= 1'b0;
                  state_q  <= ST_IDLE;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q == ST_SCAN);
   assign rd_bucket = bucket_q;
   assign rd_slot   = slot_q;
   assign done_o    = done_q;
   assign hit_o     = hit_q;
   assign port_o    = port_q;
   assign static_o  = static_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE)); // R8
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SCAN) && ($past(state_q) == ST_SCAN))
         |-> (slot_q == SLOT_W'($past(slot_q) + 1'b1))); // R5
   AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !hit_q) |-> ((port_q == '0) && !static_q)); // R10
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> ($stable(hit_q) && $stable(port_q) && $stable(static_q))); // R9
endmodule

// File: rtl/mac_hash_lookup.sv
module mac_hash_lookup #(
   parameter int MAC_W      = 48,
   parameter int IDX_W      = 8,
   parameter int WAYS       = 8,
   parameter int PORT_W     = 2,
   parameter bit RESET_DATA = 1'b0,
   localparam int SLOT_W    = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [MAC_W-1:0]  lk_mac,
   output logic              lk_busy,
   output logic              lk_done,
   output logic              lk_hit,
   output logic [PORT_W-1:0] lk_port,
   output logic              lk_static,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_bucket,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [MAC_W-1:0]  wr_mac,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              wr_static,
   input  logic              wr_valid
);
   if (WAYS < 2 || (1 << SLOT_W) != WAYS) begin : g_bad_ways
      $error("mac_hash_lookup: WAYS must be a power of two, at least 2");
   end
   if (PORT_W < 1 || IDX_W < 1) begin : g_bad_width
      $error("mac_hash_lookup: PORT_W and IDX_W must be positive");
   end

   logic [IDX_W-1:0]  req_bucket;
   logic [IDX_W-1:0]  rd_bucket;
   logic [SLOT_W-1:0] rd_slot;
   logic              rd_valid;
   logic [MAC_W-1:0]  rd_mac;
   logic [PORT_W-1:0] rd_port;
   logic              rd_static;
   logic              accept;

   mhl_hash #(.MAC_W(MAC_W), .IDX_W(IDX_W)) u_hash (
      .mac_i (lk_mac),
      .idx_o (req_bucket)
   );

   mhl_table #(
      .MAC_W(MAC_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W),
      .PORT_W(PORT_W), .RESET_DATA(RESET_DATA)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_bucket (wr_bucket),
      .wr_slot   (wr_slot),
      .wr_valid  (wr_valid),
      .wr_mac    (wr_mac),
      .wr_port   (wr_port),
      .wr_static (wr_static),
      .rd_bucket (rd_bucket),
      .rd_slot   (rd_slot),
      .rd_valid  (rd_valid),
      .rd_mac    (rd_mac),
      .rd_port   (rd_port),
      .rd_static (rd_static)
   );

   mhl_search #(
      .MAC_W(MAC_W), .IDX_W(IDX_W), .WAYS(WAYS),
      .SLOT_W(SLOT_W), .PORT_W(PORT_W)
   ) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (lk_valid),
      .req_mac    (lk_mac),
      .req_bucket (req_bucket),
      .busy_o     (lk_busy),
      .rd_bucket  (rd_bucket),
      .rd_slot    (rd_slot),
      .rd_valid   (rd_valid),
      .rd_mac     (rd_mac),
      .rd_port    (rd_port),
      .rd_static  (rd_static),
      .done_o     (lk_done),
      .hit_o      (lk_hit),
      .port_o     (lk_port),
      .static_o   (lk_static)
   );

   assign accept = lk_valid && !lk_busy;

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> lk_busy); // R8
   AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lk_hit) |-> lk_done); // R4
endmodule

// File: tb/mac_hash_lookup_test.sv
module mac_hash_lookup_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_mac = '0;
   logic        lk_busy, lk_done, lk_hit, lk_static;
   logic [1:0]  lk_port;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_bucket = '0;
   logic [2:0]  wr_slot = '0;
   logic [47:0] wr_mac = '0;
   logic [1:0]  wr_port = '0;
   logic        wr_static = 1'b0;
   logic        wr_valid = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   mac_hash_lookup uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_mac(lk_mac),
      .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit),
      .lk_port(lk_port), .lk_static(lk_static), .wr_en(wr_en),
      .wr_bucket(wr_bucket), .wr_slot(wr_slot), .wr_mac(wr_mac),
      .wr_port(wr_port), .wr_static(wr_static), .wr_valid(wr_valid)
   );

   localparam logic [47:0] MAC_A = 48'h0000_0000_0011;
   localparam logic [47:0] MAC_B = 48'h0000_0000_1100;
   localparam logic [47:0] MAC_C = 48'h0102_0304_0506;
   localparam logic [47:0] MAC_D = 48'h0000_0000_0101;
   localparam logic [47:0] MAC_E = 48'h0000_0000_0022;
   localparam logic [47:0] MAC_F = 48'h0000_0000_0033;
   localparam logic [47:0] MAC_U = 48'hFFFF_FFFF_FFFF;

   typedef struct packed {
      logic [47:0] mac;
      logic        hit;
      logic [1:0]  port;
      logic        stat;
      logic [7:0]  lat;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{MAC_A, 1'b1, 2'd1, 1'b0, 8'd1},  // slot 0
      '{MAC_B, 1'b1, 2'd2, 1'b1, 8'd4},  // slot 3, shares bucket with A
      '{MAC_C, 1'b1, 2'd3, 1'b0, 8'd8},  // slot 7
      '{MAC_D, 1'b0, 2'd0, 1'b0, 8'd8},  // stored in a wrong bucket
      '{MAC_E, 1'b1, 2'd1, 1'b0, 8'd3},  // duplicate at slots 2 and 5
      '{MAC_F, 1'b1, 2'd3, 1'b0, 8'd5},  // invalid copy at slot 1
      '{MAC_U, 1'b0, 2'd0, 1'b0, 8'd8}   // empty bucket
   };

   function automatic logic [7:0] fold(input logic [47:0] m);
      return m[7:0] ^ m[15:8] ^ m[23:16] ^ m[31:24] ^ m[39:32] ^ m[47:40];
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input logic [2:0] s, input logic [47:0] m,
                      input logic [1:0] p, input logic st, input logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_bucket = b; wr_slot = s; wr_mac = m;
      wr_port = p; wr_static = st; wr_valid = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input logic [47:0] m, output int lat, output logic h,
                         output logic [1:0] p, output logic st);
      @(negedge clk);
      lk_valid = 1'b1; lk_mac = m;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      check("R8 busy after accept", 64'(lk_busy), 64'd1);
      lat = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lk_done) break;
      end
      h = lk_hit; p = lk_port; st = lk_static;
   endtask

   initial begin
      int lat;
      logic h, st;
      logic [1:0] p;

      repeat (3) @(negedge clk);
      check("R1 done at reset", 64'(lk_done), 64'd0);
      check("R1 busy at reset", 64'(lk_busy), 64'd0);
      check("R1 hit/port/static at reset", {60'd0, lk_hit, lk_port, lk_static}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty table misses
      lookup(MAC_A, lat, h, p, st);
      check("R1 empty table hit", 64'(h), 64'd0);
      check("R1 empty table latency", 64'(lat), 64'd8);

      // load the table (R3)
      put(fold(MAC_A), 3'd0, MAC_A, 2'd1, 1'b0, 1'b1);
      put(fold(MAC_B), 3'd3, MAC_B, 2'd2, 1'b1, 1'b1);
      put(fold(MAC_C), 3'd7, MAC_C, 2'd3, 1'b0, 1'b1);
      put(8'h05,       3'd0, MAC_D, 2'd1, 1'b0, 1'b1);
      put(fold(MAC_E), 3'd2, MAC_E, 2'd1, 1'b0, 1'b1);
      put(fold(MAC_E), 3'd5, MAC_E, 2'd2, 1'b1, 1'b1);
      put(fold(MAC_F), 3'd1, MAC_F, 2'd2, 1'b1, 1'b0);
      put(fold(MAC_F), 3'd4, MAC_F, 2'd3, 1'b0, 1'b1);

      // vector table: R2 bucket choice, R4 result, R5 latency, R6 priority, R7 skip, R10 miss
      for (int v = 0; v < NVEC; v++) begin
         lookup(VECS[v].mac, lat, h, p, st);
         check($sformatf("R2/R4 vector %0d hit", v), 64'(h), 64'(VECS[v].hit));
         check($sformatf("R4/R6/R7 vector %0d port", v), 64'(p), 64'(VECS[v].port));
         check($sformatf("R4/R10 vector %0d static", v), 64'(st), 64'(VECS[v].stat));
         check($sformatf("R5 vector %0d latency", v), 64'(lat), 64'(VECS[v].lat));
      end

      // R9: one-cycle done, results held
      lookup(MAC_B, lat, h, p, st);
      @(negedge clk);
      check("R9 done drops", 64'(lk_done), 64'd0);
      check("R9 hit held", {61'd0, lk_hit, lk_port}, {61'd0, 1'b1, 2'd2});
      repeat (3) @(negedge clk);
      check("R9 static held", 64'(lk_static), 64'd1);

      // R8: requests during a search are dropped
      @(negedge clk);
      lk_valid = 1'b1; lk_mac = MAC_B;
      @(posedge clk);
      @(negedge clk);
      lk_mac = MAC_C;
      lat = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat == 3) lk_valid = 1'b0;
         if (lk_done) break;
      end
      lk_valid = 1'b0;
      check("R8 first result latency", 64'(lat), 64'd4);
      check("R8 first result port", 64'(lk_port), 64'd2);
      begin
         int extra = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (lk_done || lk_busy) extra++;
         end
         check("R8 dropped request gave no result", 64'(extra), 64'd0);
      end

      // R3: overwrite slot contents
      put(fold(MAC_A), 3'd0, MAC_A, 2'd3, 1'b1, 1'b1);
      lookup(MAC_A, lat, h, p, st);
      check("R3 overwritten port", {61'd0, h, p}, {61'd0, 1'b1, 2'd3});
      check("R3 overwritten static", 64'(st), 64'd1);

      // R7: invalidated slot no longer hits
      put(fold(MAC_A), 3'd0, MAC_A, 2'd3, 1'b1, 1'b0);
      lookup(MAC_A, lat, h, p, st);
      check("R7 invalidated slot hit", 64'(h), 64'd0);
      check("R10 miss fields", {62'd0, p}, 64'd0);
      check("R7 invalidated latency", 64'(lat), 64'd8);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule